// File: doc/BRIEF.md
# Binary to Residue Converter

This block turns an unsigned binary word into its four residue digits for the moduli 8, 7, 5 and 3 without using a divider. The power-of-two digit is simply the low bits of the word. For each odd modulus a lane keeps a running sum. Every set input bit j adds the constant 2^j reduced by that modulus. The addition wraps, so the sum always stays below the modulus. The constants are worked out at elaboration into a small table in each lane.

Work is sequential and handles one input bit per clock. A start pulse captures the word and clears the running sums. The bits are then scanned from the least significant upward, one per cycle. When the last bit has been added, a one-cycle done pulse marks the four digits as valid. The digits then hold until the next accepted start. A start that arrives during a conversion is dropped. A start in the same cycle as done begins a new conversion at once.

Top module: `bin2res_conv`

## Requirements
- R1: After reset, done is low and all four residue outputs are zero.
- R2: res_pow2 equals the three least significant bits of the captured input.
- R3: res_a, res_b and res_c equal the captured input value modulo 7, 5 and 3, for every input from 0 to 1023.
- R4: Each odd-modulus running sum is below its modulus in every cycle.
- R5: When start is sampled high while idle, done is high exactly in the cycle after the tenth following rising edge, and it stays high for a single cycle.
- R6: A start pulse that arrives while a conversion is in progress has no effect on that conversion's timing or its result.
- R7: Between done and the next accepted start, all residue outputs hold their values.
- R8: Input 164 gives the digits 4, 3, 4 and 2 for the moduli 8, 7, 5 and 3.
- R9: A start that is sampled in the cycle where done is high is accepted and begins a new conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Capture bin_in and begin a conversion when idle |
| bin_in | input | 10 | Unsigned binary operand |
| res_pow2 | output | 3 | Residue modulo 8 |
| res_a | output | 3 | Residue modulo 7 |
| res_b | output | 3 | Residue modulo 5 |
| res_c | output | 2 | Residue modulo 3 |
| done | output | 1 | One-cycle pulse when the residues are valid |

## Verification
The bench sweeps all 1024 operand values back to back. Every wrap point of each modular adder is therefore reached, with every mix of set bits, and the result is compared against the remainder worked out in the bench. The value 164 is run on its own as a known case. The all-ones and zero operands are part of the sweep, so the longest chain of additions and the no-addition case are both seen. Separate runs inject a stray start in the middle of a conversion and leave idle gaps after done. These runs separate a converter that ignores a busy start and holds its digits from one that restarts or drifts.

// File: rtl/res_conv_pkg.sv
package res_conv_pkg;

   function automatic int pow2_mod(input int j, input int m);
      int r;
      r = 1 % m;
      for (int i = 0; i < j; i++) r = (r * 2) % m;
      return r;
   endfunction

   function automatic int gcd_of(input int a, input int b);
      int x;
      int y;
      int t;
      x = a;
      y = b;
      while (y != 0) begin
         t = x % y;
         x = y;
         y = t;
      end
      return x;
   endfunction

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/mod_adder.sv
module mod_adder #(
   parameter int MOD = 7,
   parameter int W   = 3
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] s
);
   localparam int SW = W + 1;

   logic [SW-1:0] sum_w;
   logic [SW-1:0] red_w;

   always_comb begin
      sum_w = {1'b0, a} + {1'b0, b};
      red_w = sum_w - SW'(MOD);
      s     = (sum_w >= SW'(MOD)) ? red_w[W-1:0] : sum_w[W-1:0];
   end
endmodule

// File: rtl/conv_seq.sv
module conv_seq #(
   parameter int IN_W = 10,
   parameter int IW   = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [IN_W-1:0] din,
   output logic            load,
   output logic            step,
   output logic            cur_bit,
   output logic [IW-1:0]   idx,
   output logic            done
);
   localparam logic [IW-1:0] LAST = IW'(IN_W - 1);

   logic            busy;
   logic [IW-1:0]   cnt;
   logic [IN_W-1:0] shreg;

   assign load    = start && !busy;
   assign step    = busy;
   assign cur_bit = shreg[0];
   assign idx     = cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         cnt   <= '0;
         shreg <= '0;
         done  <= 1'b0;
      end else begin
         done <= busy && (cnt == LAST);
         if (load) begin
            busy  <= 1'b1;
            cnt   <= '0;
            shreg <= din;
         end else if (busy) begin
            shreg <= shreg >> 1;
            cnt   <= cnt + 1'b1;
            if (cnt == LAST) busy <= 1'b0;
         end
      end
   end

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R5
   AST_LOAD_BEGINS: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (busy && cnt == '0)); // R9
   AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && cnt != LAST) |=> (busy && cnt == $past(cnt) + 1'b1)); // R6
endmodule

// File: rtl/res_lane.sv
module res_lane
   import res_conv_pkg::*;
#(
   parameter int MOD  = 7,
   parameter int IN_W = 10,
   parameter int RW   = 3,
   parameter int IW   = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic            step,
   input  logic            bit_val,
   input  logic [IW-1:0]   idx,
   input  logic [IN_W-1:0] din,
   output logic [RW-1:0]   res
);
   logic [RW-1:0] acc;

   assign res = acc;

   generate
      if (is_pow2(MOD)) begin : g_lowbits
         logic unused_lane;
         assign unused_lane = ^{step, bit_val, idx, din};

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    acc <= '0;
            else if (load) acc <= RW'(din);
         end
      end else begin : g_accum
         logic [RW-1:0] pw_tbl [IN_W];
         logic [RW-1:0] addend;
         logic [RW-1:0] nxt;
         logic          unused_lane;

         assign unused_lane = ^din;

         for (genvar j = 0; j < IN_W; j++) begin : g_tbl
            assign pw_tbl[j] = RW'(pow2_mod(j, MOD));
         end

         always_comb begin
            addend = '0;
            if (bit_val && (int'(idx) < IN_W)) addend = pw_tbl[idx];
         end

         mod_adder #(.MOD(MOD), .W(RW)) u_add (
            .a (acc),
            .b (addend),
            .s (nxt)
         );

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    acc <= '0;
            else if (load) acc <= '0;
            else if (step) acc <= nxt;
         end

         AST_SUM_BELOW_MOD: assert property (@(posedge clk) disable iff (!rst_n)
            int'(acc) < MOD); // R4
      end
   endgenerate

   AST_RES_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !step) |=> $stable(res)); // R7
endmodule

// File: rtl/bin2res_conv.sv
module bin2res_conv
   import res_conv_pkg::*;
#(
   parameter int IN_W     = 10,
   parameter int POW2_MOD = 8,
   parameter int MOD_A    = 7,
   parameter int MOD_B    = 5,
   parameter int MOD_C    = 3,
   localparam int W_P = $clog2(POW2_MOD),
   localparam int W_A = $clog2(MOD_A),
   localparam int W_B = $clog2(MOD_B),
   localparam int W_C = $clog2(MOD_C)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [IN_W-1:0] bin_in,
   output logic [W_P-1:0]  res_pow2,
   output logic [W_A-1:0]  res_a,
   output logic [W_B-1:0]  res_b,
   output logic [W_C-1:0]  res_c,
   output logic            done
);
   localparam int IW = (IN_W > 1) ? $clog2(IN_W) : 1;

   generate
      if (IN_W < 1) begin : g_bad_width
         $error("IN_W must be at least 1");
      end
      if (!is_pow2(POW2_MOD) || POW2_MOD < 2) begin : g_bad_pow2
         $error("POW2_MOD must be a power of two of at least 2");
      end
      if (MOD_A < 3 || MOD_B < 3 || MOD_C < 3) begin : g_bad_small
         $error("odd moduli must be at least 3");
      end
      if (gcd_of(POW2_MOD, MOD_A) != 1 || gcd_of(POW2_MOD, MOD_B) != 1 ||
          gcd_of(POW2_MOD, MOD_C) != 1 || gcd_of(MOD_A, MOD_B) != 1 ||
          gcd_of(MOD_A, MOD_C) != 1 || gcd_of(MOD_B, MOD_C) != 1) begin : g_bad_coprime
         $error("moduli must be pairwise coprime");
      end
   endgenerate

   logic          load;
   logic          step;
   logic          cur_bit;
   logic [IW-1:0] idx;

   conv_seq #(.IN_W(IN_W), .IW(IW)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .din     (bin_in),
      .load    (load),
      .step    (step),
      .cur_bit (cur_bit),
      .idx     (idx),
      .done    (done)
   );

   res_lane #(.MOD(POW2_MOD), .IN_W(IN_W), .RW(W_P), .IW(IW)) u_lane_p (
      .clk (clk), .rst_n (rst_n), .load (load), .step (step),
      .bit_val (cur_bit), .idx (idx), .din (bin_in), .res (res_pow2)
   );

   res_lane #(.MOD(MOD_A), .IN_W(IN_W), .RW(W_A), .IW(IW)) u_lane_a (
      .clk (clk), .rst_n (rst_n), .load (load), .step (step),
      .bit_val (cur_bit), .idx (idx), .din (bin_in), .res (res_a)
   );

   res_lane #(.MOD(MOD_B), .IN_W(IN_W), .RW(W_B), .IW(IW)) u_lane_b (
      .clk (clk), .rst_n (rst_n), .load (load), .step (step),
      .bit_val (cur_bit), .idx (idx), .din (bin_in), .res (res_b)
   );

   res_lane #(.MOD(MOD_C), .IN_W(IN_W), .RW(W_C), .IW(IW)) u_lane_c (
      .clk (clk), .rst_n (rst_n), .load (load), .step (step),
      .bit_val (cur_bit), .idx (idx), .din (bin_in), .res (res_c)
   );

   AST_DONE_NEEDS_START_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(step)); // R5
endmodule

// File: tb/bin2res_conv_tb_top.sv
module bin2res_conv_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [9:0] bin_in = '0;
   logic [2:0] res_pow2;
   logic [2:0] res_a;
   logic [2:0] res_b;
   logic [1:0] res_c;
   logic       done;

   int n_tests = 0;
   int n_fail  = 0;

   typedef struct {
      int v;
      int e8;
      int e7;
      int e5;
      int e3;
   } exp_t;

   exp_t sb_q[$];
   exp_t last_e;

   always #10 clk = ~clk;

   bin2res_conv dut_i (
      .clk (clk), .rst_n (rst_n), .start (start), .bin_in (bin_in),
      .res_pow2 (res_pow2), .res_a (res_a), .res_b (res_b), .res_c (res_c),
      .done (done)
   );

   task automatic check(input string tag, input int act, input int exp_v);
      n_tests++;
      if (act != exp_v) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
      end
   endtask

   task automatic check_digits(input string tag, input exp_t e);
      check({tag, " R2 mod8"}, int'(res_pow2), e.e8);
      check({tag, " R3 mod7"}, int'(res_a), e.e7);
      check({tag, " R3 mod5"}, int'(res_b), e.e5);
      check({tag, " R3 mod3"}, int'(res_c), e.e3);
   endtask

   // driver: pushes expected item, pulses start, measures latency
   task automatic run(input int v, input bit glitch, input bit chk_lat);
      exp_t e;
      int   n;
      e.v = v; e.e8 = v % 8; e.e7 = v % 7; e.e5 = v % 5; e.e3 = v % 3;
      sb_q.push_back(e);
      last_e = e;
      start  = 1'b1;
      bin_in = 10'(v);
      @(negedge clk);
      start = 1'b0;
      n = 1;
      while (!done && n < 40) begin
         @(negedge clk);
         n++;
         if (glitch && n == 5) begin
            start  = 1'b1;
            bin_in = 10'(v ^ 10'h2A5);
         end else begin
            start = 1'b0;
         end
      end
      if (chk_lat) check("R5 start-to-done cycles", n, 11);
   endtask

   // monitor: pops on done and compares
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (sb_q.size() == 0) begin
            check("R5 done without pending item", 1, 0);
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            check_digits($sformatf("value %0d", e.v), e);
            if (e.v == 164) begin
               check("R8 164 mod8", int'(res_pow2), 4);
               check("R8 164 mod7", int'(res_a), 3);
               check("R8 164 mod5", int'(res_b), 4);
               check("R8 164 mod3", int'(res_c), 2);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset done", int'(done), 0);
      check("R1 reset mod8", int'(res_pow2), 0);
      check("R1 reset mod7", int'(res_a), 0);
      check("R1 reset mod5", int'(res_b), 0);
      check("R1 reset mod3", int'(res_c), 0);
      rst_n = 1'b1;
      @(negedge clk);

      run(164, 1'b0, 1'b1);
      @(negedge clk);
      check("R5 done single cycle", int'(done), 0);
      repeat (4) @(negedge clk);
      check_digits("R7 hold after done", last_e);

      run(1023, 1'b1, 1'b1);
      @(negedge clk);
      check("R6 glitch no extra done", int'(done), 0);
      check_digits("R6 after stray start", last_e);

      // R9: back-to-back sweep over all inputs
      for (int v = 0; v < 1024; v++) run(v, 1'b0, (v % 64) == 0);

      @(negedge clk);
      repeat (3) @(negedge clk);
      check_digits("R7 idle hold", last_e);
      check("R9 scoreboard drained", sb_q.size(), 0);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule